// File: doc/BRIEF.md
# Wide-Bus Frame CRC Engine

This block computes a cyclic redundancy check over a frame delivered on a parallel bus that carries several bytes per clock. Byte lane 0, the lowest eight bits of the word, is the first byte on the wire. Lanes after it follow in order. Every word of a frame is full except possibly the last, which may stop at any byte boundary. The valid bytes of the last word are packed toward lane 0. The register is updated once per accepted word, with no stall cycles. For the final word, the block uses the update for exactly as many bytes as are valid.

The next-state logic is the plain bit-at-a-time shift algorithm, unrolled over every bit of the word. One intermediate result is tapped after each byte. A small multiplexer, driven by the final-word byte count, picks the result that applies. This keeps the selection behind the XOR tree instead of inside it. The following are parameters:
- the generator polynomial
- the register width
- the start value
- input bit order
- output reflection
- the final XOR mask

A start-of-frame word seeds the register from the start value and the word together in the same cycle, so frames can follow each other with no gap.

Top module: `crc_wide_frame`

## Requirements
- R1: While reset is held and after its release with no word accepted, `crc_out` equals the formatted start value (start value, reflected if REFOUT is set, XORed with XOROUT) and `crc_done` is 0.
- R2: The reference algorithm for a frame is as follows. The register starts at INIT. Each byte is processed in lane order, lane 0 first. Bits within a byte are taken LSB first when REFIN=1, else MSB first. For each bit, the feedback is the register MSB XOR the bit. The register shifts left by one and is XORed with POLY when the feedback is 1. When the result is presented, `crc_out` equals this register after the final byte, reflected when REFOUT=1 and then XORed with XOROUT.
- R3: On the end-of-frame word, `in_count` = n with 1 <= n < BYTES means only lanes 0..n-1 enter the CRC. The contents of higher lanes have no effect.
- R4: `in_count` = 0 on the end-of-frame word means all BYTES lanes are valid.
- R5: On words without `in_eof`, `in_count` is ignored and every lane is used.
- R6: A valid word with `in_sof` restarts the CRC from INIT including that word, in the same cycle, even in the middle of a frame. A new frame's first word may follow the previous end-of-frame word directly.
- R7: `crc_done` is 1 for exactly the cycle after an end-of-frame word is accepted, and 0 otherwise.
- R8: In any cycle without an accepted word, `crc_out` keeps its value.
- R9: A valid word without `in_sof` while no frame is open is ignored. It does not change `crc_out` and does not raise `crc_done`.
- R10: With INIT = 0 and XOROUT = 0, adding leading 0x00 bytes to a frame leaves the result unchanged.
- R11: With the default parameters, the ASCII bytes "123456789" give 32'hCBF43926.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Word on `in_data` is presented this cycle |
| in_sof | input | 1 | Word is the first of a frame |
| in_eof | input | 1 | Word is the last of a frame |
| in_count | input | $clog2(BYTES) | Valid bytes in the last word, 0 meaning all |
| in_data | input | 8*BYTES | Data word, lane 0 in bits 7:0 |
| crc_out | output | CRC_W | Formatted CRC register |
| crc_done | output | 1 | One-cycle pulse after an end-of-frame word |

## Verification
Both the CRC value and the done pulse are due in the cycle right after the clock edge that accepts the end-of-frame word, because exactly one register stage lies in between. The bench drives each word on a falling edge. It checks the value, the pulse and the held output on the next falling edge, so every sample falls in the first cycle the result is due. It then launches the next frame's first word at that same falling edge, which tests gapless frames. Hold and ignore checks sample each idle cycle that follows.

// File: rtl/crcw_pkg.sv
package crcw_pkg;

  localparam int MAXW = 64;
  typedef logic [MAXW-1:0] crcw_t;

  function automatic crcw_t crcw_mask(input int w);
    crcw_t m;
    m = '0;
    for (int i = 0; i < MAXW; i++)
      if (i < w) m[i] = 1'b1;
    return m;
  endfunction

  // One byte through the bit-serial shift register, register MSB-first.
  function automatic crcw_t crcw_byte(input crcw_t s, input logic [7:0] d,
                                      input int w, input crcw_t poly,
                                      input logic refin);
    crcw_t r;
    logic  b;
    logic  fb;
    r = s;
    for (int j = 0; j < 8; j++) begin
      b  = refin ? d[j] : d[7-j];
      fb = r[w-1] ^ b;
      r  = r << 1;
      if (fb) r = r ^ poly;
    end
    return r & crcw_mask(w);
  endfunction

endpackage

// File: rtl/crcw_byte_chain.sv
module crcw_byte_chain #(
  parameter int              BYTES = 4,
  parameter int              CRC_W = 32,
  parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7,
  parameter logic            REFIN = 1'b1
) (
  input  logic [CRC_W-1:0]   seed,
  input  logic [8*BYTES-1:0] data,
  output logic [CRC_W-1:0]   partial [BYTES]
);
  import crcw_pkg::*;

  localparam crcw_t POLY_X = crcw_t'(POLY);

  // partial[k] holds the register after lanes 0..k have been shifted in.
  always_comb begin
    crcw_t acc;
    acc = crcw_t'(seed);
    for (int k = 0; k < BYTES; k++) begin
      acc        = crcw_byte(acc, data[8*k +: 8], CRC_W, POLY_X, REFIN);
      partial[k] = acc[CRC_W-1:0];
    end
  end

endmodule

// File: rtl/crcw_tail_pick.sv
module crcw_tail_pick #(
  parameter int BYTES = 4,
  parameter int CRC_W = 32,
  localparam int CNT_W = $clog2(BYTES)
) (
  input  logic [CRC_W-1:0] partial [BYTES],
  input  logic             last,
  input  logic [CNT_W-1:0] count,
  output logic [CRC_W-1:0] picked
);

  // Full word unless this is the final word with a non-zero count.
  always_comb begin
    picked = partial[BYTES-1];
    if (last)
      for (int k = 1; k < BYTES; k++)
        if (count == CNT_W'(k)) picked = partial[k-1];
  end

endmodule

// File: rtl/crcw_out_fmt.sv
module crcw_out_fmt #(
  parameter int               CRC_W  = 32,
  parameter logic             REFOUT = 1'b1,
  parameter logic [CRC_W-1:0] XOROUT = 32'hFFFFFFFF
) (
  input  logic [CRC_W-1:0] state,
  output logic [CRC_W-1:0] shown
);
  logic [CRC_W-1:0] ordered;

  generate
    if (REFOUT) begin : g_reflect
      for (genvar i = 0; i < CRC_W; i++) begin : g_bit
        assign ordered[i] = state[CRC_W-1-i];
      end
    end else begin : g_straight
      assign ordered = state;
    end
  endgenerate

  assign shown = ordered ^ XOROUT;

endmodule

// File: rtl/crc_wide_frame.sv
module crc_wide_frame #(
  parameter int               BYTES  = 4,
  parameter int               CRC_W  = 32,
  parameter logic [CRC_W-1:0] POLY   = 32'h04C11DB7,
  parameter logic [CRC_W-1:0] INIT   = 32'hFFFFFFFF,
  parameter logic             REFIN  = 1'b1,
  parameter logic             REFOUT = 1'b1,
  parameter logic [CRC_W-1:0] XOROUT = 32'hFFFFFFFF,
  localparam int CNT_W  = $clog2(BYTES),
  localparam int DATA_W = 8 * BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [DATA_W-1:0] in_data,
  output logic [CRC_W-1:0]  crc_out,
  output logic              crc_done
);

  logic [CRC_W-1:0] state_q;
  logic             in_frame_q;
  logic             done_q;

  // Named internal events.
  logic             accept_w;
  logic             last_w;
  logic [CRC_W-1:0] seed_w;
  logic [CRC_W-1:0] next_w;
  logic [CRC_W-1:0] partial_w [BYTES];

  assign accept_w = in_valid && (in_sof || in_frame_q);
  assign last_w   = in_eof;
  assign seed_w   = in_sof ? INIT : state_q;

  crcw_byte_chain #(
    .BYTES(BYTES), .CRC_W(CRC_W), .POLY(POLY), .REFIN(REFIN)
  ) u_chain (
    .seed(seed_w), .data(in_data), .partial(partial_w)
  );

  crcw_tail_pick #(
    .BYTES(BYTES), .CRC_W(CRC_W)
  ) u_pick (
    .partial(partial_w), .last(last_w), .count(in_count), .picked(next_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= INIT;
      in_frame_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= accept_w && in_eof;
      if (accept_w) begin
        state_q    <= next_w;
        in_frame_q <= !in_eof;
      end
    end
  end

  crcw_out_fmt #(
    .CRC_W(CRC_W), .REFOUT(REFOUT), .XOROUT(XOROUT)
  ) u_fmt (
    .state(state_q), .shown(crc_out)
  );

  assign crc_done = done_q;

  // R8: nothing presented, nothing changes.
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(crc_out))
    else $error("p_hold_r8");

  // R9: stray word outside a frame leaves output and pulse untouched.
  p_outside_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame_q && in_valid && !in_sof) |=> ($stable(crc_out) && !crc_done))
    else $error("p_outside_r9");

  // R7: a pulse always traces back to an end-of-frame word.
  p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    crc_done |-> $past(in_valid && in_eof))
    else $error("p_done_cause_r7");

  // R7: single-word frame completes on the next cycle.
  p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && in_eof) |=> crc_done)
    else $error("p_single_r7");

  // R6: a start word that is not also the last opens a frame.
  p_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && !in_eof) |=> in_frame_q)
    else $error("p_open_r6");

endmodule

// File: tb/test_crc_wide_frame.sv
module test_crc_wide_frame;

  localparam int NB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic [1:0]  in_count = '0;
  logic [31:0] in_data = '0;
  logic [31:0] crc_a, crc_z;
  logic        done_a, done_z;

  int checks = 0;
  int errors = 0;
  logic [7:0]  fb [0:255];
  logic [31:0] last_a;

  always #5 clk = ~clk;

  crc_wide_frame i_crc_wide_frame (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_count(in_count), .in_data(in_data),
    .crc_out(crc_a), .crc_done(done_a));

  crc_wide_frame #(.INIT(32'h0), .REFIN(1'b0), .REFOUT(1'b0), .XOROUT(32'h0))
  i_zero (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_count(in_count), .in_data(in_data),
    .crc_out(crc_z), .crc_done(done_z));

  // Reference: reflected-input bits fed one at a time, output formatted after.
  function automatic logic [31:0] ref_crc(input int n, input logic [31:0] init,
                                          input bit refin, input bit refout,
                                          input logic [31:0] xo);
    logic [31:0] s;
    logic [31:0] o;
    s = init;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++) begin
        logic b;
        b = refin ? fb[i][j] : fb[i][7-j];
        if (s[31] ^ b) s = {s[30:0], 1'b0} ^ 32'h04C11DB7;
        else           s = {s[30:0], 1'b0};
      end
    for (int i = 0; i < 32; i++) o[i] = refout ? s[31-i] : s[i];
    return o ^ xo;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fill_random(input int n);
    for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
  endtask

  // Drives n bytes from fb as one frame, then checks on the next falling edge.
  task automatic run_frame(input int n, input string tag);
    int nw;
    logic [31:0] ea, ez;
    nw = (n + NB - 1) / NB;
    for (int w = 0; w < nw; w++) begin
      in_valid = 1'b1;
      in_sof   = (w == 0);
      in_eof   = (w == nw - 1);
      for (int l = 0; l < NB; l++)
        in_data[8*l +: 8] = (w*NB + l < n) ? fb[w*NB + l] : 8'($urandom);
      in_count = (w == nw - 1) ? 2'(n % NB) : 2'($urandom);
      @(negedge clk);
    end
    ea = ref_crc(n, 32'hFFFFFFFF, 1'b1, 1'b1, 32'hFFFFFFFF);
    ez = ref_crc(n, 32'h0, 1'b0, 1'b0, 32'h0);
    chk(crc_a == ea, tag, crc_a, ea);
    chk(crc_z == ez, tag, crc_z, ez);
    chk(done_a == 1'b1, "R7 done after eof", 32'(done_a), 32'd1);
    last_a = crc_a;
  endtask

  task automatic idle(input int k);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      chk(done_a == 1'b0, "R7 done low when idle", 32'(done_a), 32'd0);
      chk(crc_a == last_a, "R8 hold", crc_a, last_a);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] zref;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: formatted start value during and after reset.
    chk(crc_a == ref_crc(0, 32'hFFFFFFFF, 1'b1, 1'b1, 32'hFFFFFFFF), "R1 reset value",
        crc_a, ref_crc(0, 32'hFFFFFFFF, 1'b1, 1'b1, 32'hFFFFFFFF));
    chk(done_a == 1'b0, "R1 done low", 32'(done_a), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(crc_z == 32'h0, "R1 zero-start value", crc_z, 32'h0);
    last_a = crc_a;

    // R11: check string across a partial last word.
    for (int i = 0; i < 9; i++) fb[i] = 8'h31 + 8'(i);
    run_frame(9, "R2 check string");
    chk(crc_a == 32'hCBF43926, "R11 check value", crc_a, 32'hCBF43926);
    idle(2);

    // R3 and R4: every final-word byte count, single and multi word.
    for (int n = 1; n <= 2*NB; n++) begin
      fill_random(n);
      run_frame(n, (n % NB == 0) ? "R4 full last word" : "R3 partial last word");
      idle(1);
    end

    // R6: back-to-back frames, no idle cycle.
    fill_random(11); run_frame(11, "R6 first of pair");
    fill_random(6);  run_frame(6,  "R6 second of pair");
    idle(1);

    // R9: stray words outside any frame.
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_sof = 1'b0; in_eof = 1'(i & 1);
      in_data = $urandom; in_count = 2'($urandom);
      @(negedge clk);
      chk(crc_a == last_a, "R9 stray word ignored", crc_a, last_a);
      chk(done_a == 1'b0, "R9 no pulse", 32'(done_a), 32'd0);
    end

    // R6: start word in mid-frame restarts the CRC. R5 via random mid counts.
    in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b0; in_data = $urandom;
    @(negedge clk);
    fill_random(14); run_frame(14, "R6 restart and R5 mid counts");
    idle(1);

    // R10: leading zero bytes with a zero start value.
    fill_random(7);
    zref = ref_crc(7, 32'h0, 1'b0, 1'b0, 32'h0);
    run_frame(7, "R10 base frame");
    idle(1);
    for (int z = 1; z <= NB + 1; z++) begin
      for (int i = 6; i >= 0; i--) fb[i + z] = fb[i + z - 1];
      fb[z - 1] = 8'h00;
      for (int i = 0; i < z; i++) fb[i] = 8'h00;
      run_frame(7 + z, "R10 framing");
      chk(crc_z == zref, "R10 leading zeros", crc_z, zref);
      idle(1);
    end

    // R2: random frames with random gaps.
    for (int f = 0; f < 60; f++) begin
      int n;
      n = 1 + int'($urandom % 37);
      fill_random(n);
      run_frame(n, "R2 random frame");
      if ($urandom % 3 != 0) idle(1 + int'($urandom % 2));
    end
    idle(1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule